// File: doc/BRIEF.md
# Residue-Triple Slice Locator

This block takes an integer held as three residues over the moduli 2^N-1, 2^N and 2^N+1 and returns which 2^N-wide slice of the representable range the integer falls in. In other words, it returns the integer divided by 2^N and rounded down. The slice number is a 2N-bit value. The block never rebuilds the binary integer.

It works entirely on narrow quantities. Two modular differences are taken between the residues, one on the 2^N-1 side and one on the 2^N+1 side. Each is corrected by a sign-selected offset. A third difference modulo 2^N-1 mixes the first two. A one-bit right rotation halves that mixed difference modulo 2^N-1. A single N+1-bit add then splits the sum into the high and low halves of the result, and the halves are joined by wiring.

A typical use is overflow screening in a residue-arithmetic datapath. The slice numbers of the operands and of the result can be compared in plain binary at 2N bits. The result is registered once, with a synchronous active-high reset. A parameter can remove the register.

Top module: `rns_group_index`

## Requirements
- R1: For every integer X in 0 to (2^N-1)·2^N·(2^N+1)-1, given the residues X mod 2^N-1 on `res_lo_i`, X mod 2^N on `res_pw_i` and X mod 2^N+1 on `res_hi_i`, `group_o` equals floor(X / 2^N).
- R2: With the output register enabled (the default), `group_o` changes only at a rising clock edge. It shows the slice of the residues present at the previous edge and holds between edges.
- R3: While `rst` is high at a rising edge, `group_o` becomes 0 whatever the residue inputs are.
- R4: `group_o` mod (2^N-1) equals (`res_lo_i` − `res_pw_i`) mod (2^N-1).
- R5: `group_o` mod (2^N+1) equals (`res_pw_i` − `res_hi_i`) mod (2^N+1).
- R6: The largest representable integer maps to 2^(2N)-2. No valid input produces a larger slice.
- R7: One case drives the mixed difference to its single exceptional raw value, −2^N. This happens when the first difference is 0 and the second is 2^N. The slice must still be exact: 35 for N=3 and 135 for N=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output |
| res_lo_i | input | N | Residue modulo 2^N-1 |
| res_pw_i | input | N | Residue modulo 2^N |
| res_hi_i | input | N+1 | Residue modulo 2^N+1 |
| group_o | output | 2N | Slice index, floor(X / 2^N) |

## Verification
The bench walks the whole representable range for both N=3 and N=4, so every combination of offset corrections is reached. This includes the wrap where the 2^N+1 difference equals 2^N and the final add carries into the high half. A design that dropped the special-value multiplexer would be wrong only at slices 35 and 135 (R7): it would return a value one step off modulo 2^N-1. A rotation in the wrong direction, or a lost carry from the low half, would break the independent mod-(2^N-1) and mod-(2^N+1) cross-checks (R4, R5). That holds even where a wrong slice happens to look plausible. The top of the range checks that nothing spills past 2^(2N)-2. Samples taken between edges catch an output that follows its inputs combinationally.

// File: rtl/rns_grp_pkg.sv
package rns_grp_pkg;

  // modulus just below the power of two
  function automatic int lo_mod(input int n);
    return (1 << n) - 1;
  endfunction

  // modulus just above the power of two
  function automatic int hi_mod(input int n);
    return (1 << n) + 1;
  endfunction

endpackage

// File: rtl/rns_sub_mlo.sv
// (min_i - sub_i) mod (2^N-1), with sub_i up to SW bits wide.
// A negative raw difference gets the modulus added back. With HAS_EXC the
// raw value -2^N, which needs twice the modulus, is caught by a 2:1 mux.
module rns_sub_mlo #(
  parameter int N       = 4,
  parameter int SW      = 4,
  parameter bit HAS_EXC = 1'b0
) (
  input  logic [N-1:0]  min_i,
  input  logic [SW-1:0] sub_i,
  output logic [N-1:0]  dif_o
);
  localparam int W = N + 2;
  localparam logic [N-1:0] OFS     = N'(rns_grp_pkg::lo_mod(N));
  localparam logic [W-1:0] EXC_RAW = {2'b11, {N{1'b0}}};
  localparam logic [N-1:0] EXC_OUT = {{(N-1){1'b1}}, 1'b0};

  logic [W-1:0] raw;
  logic [N-1:0] base;

  always_comb begin
    raw  = W'(min_i) - W'(sub_i);
    base = raw[N-1:0] + (raw[W-1] ? OFS : '0);
  end

  generate
    if (HAS_EXC) begin : g_exc
      logic unused_mid;
      assign unused_mid = raw[N];
      assign dif_o = (raw == EXC_RAW) ? EXC_OUT : base;
    end else begin : g_plain
      logic [1:0] unused_top;
      assign unused_top = raw[N+1:N];
      assign dif_o = base;
    end
  endgenerate

endmodule

// File: rtl/rns_sub_mhi.sv
// (min_i - sub_i) mod (2^N+1); the result spans 0..2^N, so it is N+1 bits.
module rns_sub_mhi #(
  parameter int N = 4
) (
  input  logic [N-1:0] min_i,
  input  logic [N:0]   sub_i,
  output logic [N:0]   dif_o
);
  localparam int W  = N + 2;
  localparam int RW = N + 1;
  localparam logic [N:0] OFS = RW'(rns_grp_pkg::hi_mod(N));

  logic [W-1:0] raw;

  always_comb begin
    raw   = W'(min_i) - W'(sub_i);
    dif_o = raw[N:0] + (raw[W-1] ? OFS : '0);
  end

endmodule

// File: rtl/rns_grp_merge.sv
// slice = a + t*(2^N+1) = t*2^N + (t + a). The low half is the N-bit part
// of t+a, and its carry bumps t to form the high half.
module rns_grp_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0]   t_i,
  input  logic [N:0]     a_i,
  output logic [2*N-1:0] grp_o
);
  logic [N:0]   part;
  logic [N-1:0] upper;

  always_comb begin
    part  = {1'b0, t_i} + a_i;
    upper = t_i + N'(part[N]);
    grp_o = {upper, part[N-1:0]};
  end

endmodule

// File: rtl/rns_group_index.sv
module rns_group_index #(
  parameter int N       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   res_lo_i,
  input  logic [N-1:0]   res_pw_i,
  input  logic [N:0]     res_hi_i,
  output logic [2*N-1:0] group_o
);
  localparam int M1    = rns_grp_pkg::lo_mod(N);
  localparam int M3    = rns_grp_pkg::hi_mod(N);
  localparam int G_MAX = (1 << (2 * N)) - 2;

  logic [N-1:0]   dif_lo;     // slice mod 2^N-1
  logic [N:0]     dif_hi;     // slice mod 2^N+1
  logic [N-1:0]   dif_cross;  // (dif_lo - dif_hi) mod 2^N-1
  logic [N-1:0]   halved;     // dif_cross / 2 mod 2^N-1
  logic [2*N-1:0] grp_c;

  rns_sub_mlo #(.N(N), .SW(N), .HAS_EXC(1'b0)) u_dlo (
    .min_i(res_lo_i), .sub_i(res_pw_i), .dif_o(dif_lo)
  );

  rns_sub_mhi #(.N(N)) u_dhi (
    .min_i(res_pw_i), .sub_i(res_hi_i), .dif_o(dif_hi)
  );

  rns_sub_mlo #(.N(N), .SW(N+1), .HAS_EXC(1'b1)) u_dx (
    .min_i(dif_lo), .sub_i(dif_hi), .dif_o(dif_cross)
  );

  // a right rotation multiplies by the inverse of 2 modulo 2^N-1
  assign halved = {dif_cross[0], dif_cross[N-1:1]};

  rns_grp_merge #(.N(N)) u_mrg (
    .t_i(halved), .a_i(dif_hi), .grp_o(grp_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [2*N-1:0] group_q;
      always_ff @(posedge clk) begin
        if (rst) group_q <= '0;
        else     group_q <= grp_c;
      end
      assign group_o = group_q;
    end else begin : g_comb
      assign group_o = grp_c;
    end
  endgenerate

  // R4
  lo_residue_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(grp_c) % M1) == int'(dif_lo));

  // R5
  hi_residue_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(grp_c) % M3) == int'(dif_hi));

  // R6
  slice_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(grp_c) <= G_MAX);

  // R7
  cross_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(dif_cross) < M1);

endmodule

// File: tb/rns_group_index_bench.sv
`timescale 1ns/1ps
module rns_group_index_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic [2:0] lo3, pw3;
  logic [3:0] hi3;
  logic [5:0] g3;
  logic [3:0] lo4, pw4;
  logic [4:0] hi4;
  logic [7:0] g4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int q3[$];
  int q4[$];

  rns_group_index #(.N(3)) u_rns_group_index (
    .clk(clk), .rst(rst), .res_lo_i(lo3), .res_pw_i(pw3), .res_hi_i(hi3),
    .group_o(g3)
  );

  rns_group_index #(.N(4)) u_rns_group_index_n4 (
    .clk(clk), .rst(rst), .res_lo_i(lo4), .res_pw_i(pw4), .res_hi_i(hi4),
    .group_o(g4)
  );

  task automatic chk(input string tag, input int w, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%0d expected=%0d", tag, w, act, exp);
    end
  endtask

  function automatic int pmod(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  task automatic drive(input int x);
    int x3;
    x3  = x % 504;
    lo3 = 3'(x3 % 7);
    pw3 = 3'(x3 % 8);
    hi3 = 4'(x3 % 9);
    lo4 = 4'(x % 15);
    pw4 = 4'(x % 16);
    hi4 = 5'(x % 17);
  endtask

  task automatic verify(input int n, input int x, input int act);
    int m1, m2, m3, g;
    m1 = (1 << n) - 1;
    m2 = 1 << n;
    m3 = (1 << n) + 1;
    g  = x >> n;
    chk("R1", n, act, g);
    chk("R4", n, act % m1, pmod((x % m1) - (x % m2), m1));
    chk("R5", n, act % m3, pmod((x % m2) - (x % m3), m3));
    if (x == m1 * m2 * m3 - 1) chk("R6", n, act, (1 << (2 * n)) - 2);
    if ((g % m1) == 0 && (g % m3) == m2) chk("R7", n, act, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(4079);
    repeat (3) @(negedge clk);
    // R3: reset clears the output even with nonzero inputs present
    chk("R3", 3, int'(g3), 0);
    chk("R3", 4, int'(g4), 0);
    rst = 1'b0;
    for (int i = 0; i < 4080; i++) begin
      drive(i);
      q3.push_back(i % 504);
      q4.push_back(i);
      #1;
      // R2: output still holds the slice of the previous input
      if (i > 0) begin
        chk("R2", 3, int'(g3), ((i - 1) % 504) >> 3);
        chk("R2", 4, int'(g4), (i - 1) >> 4);
      end
      @(negedge clk);
      verify(3, q3.pop_front(), int'(g3));
      verify(4, q4.pop_front(), int'(g4));
    end
    rst = 1'b1;
    drive(4079);
    @(negedge clk);
    // R3: reset applied in mid-run
    chk("R3", 3, int'(g3), 0);
    chk("R3", 4, int'(g4), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule